// File: doc/BRIEF.md
# Huff-and-Puff Oscillator Stabilizer

This block keeps a free-running variable oscillator from wandering. Two identical binary counters divide a crystal clock and the oscillator signal down to a rate of a few tens of hertz. A one-bit correction output is produced from these two slow signals. An external analog integrator smooths that bit into the tuning voltage of the oscillator's varactor. In huff-and-puff mode the slow crystal signal is sampled on rising edges of the slow oscillator signal. This pins the oscillator to any multiple of the low reference rate, so the dial can still choose the frequency. Only slow drift of a few hertz is pulled back. A large jump, such as a retune, is simply not followed.

A static mode input can instead select a plain XOR phase comparison, which pulls toward a single fixed frequency. Both divided signals are brought out for probing. An indicator output shows the registered correction bit, so lock wander can be seen. The divided reference crosses into the oscillator clock domain through a short synchronizer chain before it is sampled.

Top module: `hp_stab`

## Requirements
- R1: The reference counter is CNT_W bits wide. It is cleared by reset, then rises by one on every `ref_clk` edge and wraps to zero after 2^CNT_W counts. `ref_div` is its bit TAP_BIT.
- R2: The oscillator counter is identical and is clocked by `osc_clk`. `osc_div` is its bit TAP_BIT, so both paths share one division ratio.
- R3: While `rst` is high at a clock edge, the counter and registers of that domain are cleared. After reset, `ref_div`, `osc_div`, `corr` and `led` are all 0.
- R4: The registered correction bit updates on the `osc_clk` edge that follows the edge on which `osc_div` rose. It takes the inverse of `ref_div` as that port stood at the `osc_clk` edge SYNC_STAGES edges earlier, or 0 if that edge came before reset was released.
- R5: The registered correction bit holds its value on every other `osc_clk` edge.
- R6: With `mode` = 1 (XOR comparison), `corr` equals `ref_div` XOR `osc_div` at all times.
- R7: With `mode` = 0 (huff-and-puff), `corr` is the registered correction bit. In both modes `led` shows the registered correction bit, which keeps running when XOR is selected. `mode` changes only while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Crystal reference clock |
| osc_clk | input | 1 | Oscillator signal used as a clock |
| rst | input | 1 | Synchronous active-high reset, taken in both clock domains |
| mode | input | 1 | 0 = huff-and-puff sampling, 1 = XOR phase comparison |
| corr | output | 1 | Correction bit to the external integrator |
| ref_div | output | 1 | Divided reference signal, for probing |
| osc_div | output | 1 | Divided oscillator signal, for probing |
| led | output | 1 | Registered correction bit, for the indicator |

## Verification
The capture of the correction bit and a transition of the divided reference can fall in the same oscillator cycle, or within the depth of the synchronizer. The two clocks are therefore chosen so that their edges never coincide but their phase sweeps through every relation over the run. Each capture then sees the reference at a different distance from its own edges. The bench records `ref_div` at every oscillator edge and predicts each captured bit from the sample taken SYNC_STAGES edges earlier. A reset raised mid-run, while a capture is pending, is judged by all outputs returning to 0 and by fresh predictions once reset is released.

// File: rtl/hp_stab_pkg.sv
package hp_stab_pkg;

  // Comparator selection carried on the static mode pin.
  typedef enum logic {
    CMP_HUFF = 1'b0,
    CMP_XOR  = 1'b1
  } cmp_mode_e;

endpackage

// File: rtl/hp_div.sv
// Free-running binary divider: wrapping counter with one tapped bit.
module hp_div #(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned TAP_BIT = 19
) (
  input  logic clk,
  input  logic rst,
  output logic tap
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign cnt_d = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign tap = cnt_q[TAP_BIT];

endmodule

// File: rtl/hp_sync.sv
// Synchronizer chain carrying the slow reference into the oscillator domain.
module hp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sr_q <= '0;
        end else begin
          sr_q[0] <= d;
          for (int i = 1; i < STAGES; i++) sr_q[i] <= sr_q[i-1];
        end
      end
      assign q = sr_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/hp_sampler.sv
// Correction flop: on a detected rise of the divided oscillator,
// capture the inverse of the synchronized divided reference.
module hp_sampler (
  input  logic clk,
  input  logic rst,
  input  logic osc_tap,
  input  logic ref_s,
  output logic q
);

  logic tap_prev_q;
  logic rise;

  assign rise = osc_tap & ~tap_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_prev_q <= 1'b0;
      q          <= 1'b0;
    end else begin
      tap_prev_q <= osc_tap;
      if (rise) q <= ~ref_s;
    end
  end

endmodule

// File: rtl/hp_stab.sv
module hp_stab
  import hp_stab_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned TAP_BIT     = 19,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic osc_clk,
  input  logic rst,
  input  logic mode,
  output logic corr,
  output logic ref_div,
  output logic osc_div,
  output logic led
);

  logic ref_sync;
  logic hp_q;

  hp_div #(.CNT_W(CNT_W), .TAP_BIT(TAP_BIT)) u_ref_div (
    .clk (ref_clk),
    .rst (rst),
    .tap (ref_div)
  );

  hp_div #(.CNT_W(CNT_W), .TAP_BIT(TAP_BIT)) u_osc_div (
    .clk (osc_clk),
    .rst (rst),
    .tap (osc_div)
  );

  hp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (osc_clk),
    .rst (rst),
    .d   (ref_div),
    .q   (ref_sync)
  );

  hp_sampler u_sampler (
    .clk     (osc_clk),
    .rst     (rst),
    .osc_tap (osc_div),
    .ref_s   (ref_sync),
    .q       (hp_q)
  );

  always_comb begin
    if (cmp_mode_e'(mode) == CMP_XOR) corr = ref_div ^ osc_div;
    else                              corr = hp_q;
  end

  assign led = hp_q;

endmodule

// File: rtl/hp_stab_chk.sv
module hp_stab_chk #(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned TAP_BIT = 19
) (
  input logic ref_clk,
  input logic osc_clk,
  input logic rst,
  input logic ref_div,
  input logic osc_div,
  input logic led
);

  localparam logic [CNT_W:0] HALF_M1 = (CNT_W+1)'((64'd1 << TAP_BIT) - 64'd1);

  logic           ref_prev, ref_seen, osc_prev, osc_seen;
  logic [CNT_W:0] ref_gap, osc_gap;

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      ref_prev <= 1'b0; ref_seen <= 1'b0; ref_gap <= '0;
    end else begin
      ref_prev <= ref_div;
      if (ref_div != ref_prev) begin
        ref_gap <= '0; ref_seen <= 1'b1;
      end else begin
        ref_gap <= ref_gap + 1'b1;
      end
    end
  end

  always_ff @(posedge osc_clk) begin
    if (rst) begin
      osc_prev <= 1'b0; osc_seen <= 1'b0; osc_gap <= '0;
    end else begin
      osc_prev <= osc_div;
      if (osc_div != osc_prev) begin
        osc_gap <= '0; osc_seen <= 1'b1;
      end else begin
        osc_gap <= osc_gap + 1'b1;
      end
    end
  end

  AST_REF_HALF_PERIOD: assert property (@(posedge ref_clk) disable iff (rst)
    ((ref_div != ref_prev) && ref_seen) |-> (ref_gap == HALF_M1)); // R1

  AST_OSC_HALF_PERIOD: assert property (@(posedge osc_clk) disable iff (rst)
    ((osc_div != osc_prev) && osc_seen) |-> (osc_gap == HALF_M1)); // R2

  AST_REF_RST_CLEAR: assert property (@(posedge ref_clk)
    $past(rst) |-> !ref_div); // R3

  AST_OSC_RST_CLEAR: assert property (@(posedge osc_clk)
    $past(rst) |-> (!osc_div && !led)); // R3

  AST_LED_AFTER_RISE: assert property (@(posedge osc_clk) disable iff (rst)
    (led != $past(led)) |-> ($past(osc_div) && !$past(osc_div, 2))); // R5

endmodule

bind hp_stab hp_stab_chk #(
  .CNT_W   (CNT_W),
  .TAP_BIT (TAP_BIT)
) u_hp_stab_chk (
  .ref_clk (ref_clk),
  .osc_clk (osc_clk),
  .rst     (rst),
  .ref_div (ref_div),
  .osc_div (osc_div),
  .led     (led)
);

// File: tb/hp_stab_bench.sv
`timescale 1ns/1ps
module hp_stab_bench;

  localparam int CNT_W       = 6;
  localparam int TAP_BIT     = 5;
  localparam int SYNC_STAGES = 2;
  localparam int MOD         = 1 << CNT_W;
  localparam int PER         = 1 << (TAP_BIT + 1);
  localparam int HALF        = 1 << TAP_BIT;

  logic ref_clk = 1'b0;
  logic osc_clk = 1'b0;
  logic rst     = 1'b1;
  logic mode    = 1'b0;
  logic corr, ref_div, osc_div, led;

  hp_stab #(
    .CNT_W(CNT_W), .TAP_BIT(TAP_BIT), .SYNC_STAGES(SYNC_STAGES)
  ) u_hp_stab (
    .ref_clk (ref_clk),
    .osc_clk (osc_clk),
    .rst     (rst),
    .mode    (mode),
    .corr    (corr),
    .ref_div (ref_div),
    .osc_div (osc_div),
    .led     (led)
  );

  // 200 MHz reference; oscillator edges fall on odd picoseconds, never on a reference edge.
  always #2.5 ref_clk = ~ref_clk;
  initial begin
    #0.111;
    forever #3.332 osc_clk = ~osc_clk;
  end

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  bit                 exp_q[$];
  int                 osc_n = 0;
  int                 ref_n = 0;
  logic [SYNC_STAGES:0] hist = '0;
  logic               exp_osc_div = 1'b0;
  logic               held = 1'b0;

  // Driver/predictor: runs at each oscillator edge and queues expected captures.
  task automatic predict_osc_edge();
    if (rst) begin
      osc_n = 0;
      hist  = '0;
      exp_q.delete();
    end else begin
      osc_n++;
      hist = {hist[SYNC_STAGES-1:0], ref_div};
      if ((osc_n % PER) == HALF + 1) exp_q.push_back(~hist[SYNC_STAGES]);
    end
    exp_osc_div = (((osc_n % MOD) >> TAP_BIT) & 1) != 0;
  endtask

  always @(posedge osc_clk) predict_osc_edge();

  always @(posedge ref_clk) begin
    if (rst) ref_n = 0;
    else     ref_n++;
  end

  // Monitor: oscillator-domain outputs, sampled at the falling edge.
  always @(negedge osc_clk) begin
    if (rst) begin
      held = 1'b0;
    end else begin
      check(osc_div == exp_osc_div, "R2 osc_div", osc_div, exp_osc_div);
      if (exp_q.size() > 0) begin
        bit b;
        b = exp_q.pop_front();
        check(led == b, "R4/R7 led capture", led, b);
        if (mode == 1'b0) check(corr == b, "R4 corr capture", corr, b);
        held = b;
      end else begin
        check(led == held, "R5 led hold", led, held);
        if (mode == 1'b0) check(corr == held, "R5 corr hold", corr, held);
      end
    end
  end

  // Monitor: reference-domain output.
  always @(negedge ref_clk) begin
    if (!rst) begin
      int e;
      e = ((ref_n % MOD) >> TAP_BIT) & 1;
      check(ref_div == e[0], "R1 ref_div", ref_div, e);
    end
  end

  // Monitor: XOR comparison, sampled between all clock edges.
  always @(negedge osc_clk) begin
    #1.0;
    if (!rst && mode) check(corr == (ref_div ^ osc_div), "R6 xor", corr, ref_div ^ osc_div);
  end

  task automatic check_cleared(input string tag);
    check(ref_div == 1'b0, {"R3 ref_div ", tag}, ref_div, 0);
    check(osc_div == 1'b0, {"R3 osc_div ", tag}, osc_div, 0);
    check(corr == 1'b0,    {"R3 corr ", tag}, corr, 0);
    check(led == 1'b0,     {"R3 led ", tag}, led, 0);
  endtask

  task automatic enter_reset(input logic new_mode);
    @(negedge ref_clk); #1;
    rst = 1'b1;
    repeat (10) @(negedge ref_clk);
    #1;
    check_cleared("in reset");
    mode = new_mode;
  endtask

  task automatic leave_reset(input int run_ns);
    @(negedge ref_clk); #1;
    rst = 1'b0;
    #(run_ns);
  endtask

  initial begin
    repeat (10) @(negedge ref_clk);
    #1;
    check_cleared("power-up");
    leave_reset(25000);          // huff-and-puff, phase sweeping (R4, R5, R7)
    enter_reset(1'b1);           // mid-run reset with state set (R3)
    leave_reset(15000);          // XOR comparison (R6, R7)
    enter_reset(1'b0);
    leave_reset(12000);          // huff-and-puff again from a fresh phase
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule